// File: doc/BRIEF.md
# Three-Channel Interval PWM Timer

This block holds three independent up-counting timer channels behind a small register bus. Each channel turns its count into a pulse-width-modulated waveform. The interval register sets the period: the counter restarts from zero once it has passed the interval value. The match register sets the high time: the output stays high while the count is below the match value. Each channel has its own clock-control word, which holds a prescaler enable, a 4-bit prescale exponent and a source select. The source select chooses between the core clock and a per-channel advance pulse from outside the block.

Each channel has three event flags: interval wrap, match and free-running overflow. Software enables each flag separately. A flag that has been set stays set until software reads its status register, and the read clears it. One interrupt line is the OR of all flags. Software sets up a channel by writing the prescale, interval and match values first. It then clears the stop bit in the counter-control register to start the waveform.

Top module: `pwm3_timer`

## Requirements
- R1: The register slots sit at group offsets clock-control 0x00, counter-control 0x0C, count 0x18, interval 0x24, match 0x30, status 0x54 and interrupt-enable 0x60. Channel n uses the group offset plus 4*n. Read data appears on `bus_rdata` in the cycle after the read strobe. A read of an address outside the map returns 0.
- R2: After reset the registers hold these values: clock-control 0, counter-control 0x21 (stopped, waveform off), interval all ones, match 0, interrupt-enable 0 and status 0. All waveform outputs and `irq_o` are 0.
- R3: While counter-control bit 0 is 1, the count holds its value.
- R4: When clock-control bit 0 is 1, the count advances once every 2^(p+1) source events, where p is clock-control bits 4:1. When bit 0 is 0, the count advances on every source event. The prescaler phase restarts from zero whenever the channel is stopped.
- R5: With clock-control bit 5 at 0, every core clock is a source event. With bit 5 at 1, a source event is a cycle in which `alt_tick_i[n]` is high.
- R6: With counter-control bit 1 set, the count runs 0..interval and then returns to 0, so a period lasts interval+1 advances. With bit 1 clear, the count runs up to 2^CNT_W-1 and then wraps to 0.
- R7: With counter-control bit 3 set, the raw level is high while count < match. With bit 3 clear, the raw level is low. Bit 6 inverts the raw level. Bit 5 set forces the output to 0 whatever the polarity.
- R8: Writing 1 to counter-control bit 4 clears the count and the prescaler phase. The bit is not stored, so it always reads 0. The other counter-control bits read back as written.
- R9: The status bits are: bit 0, interval wrap; bit 1, match (an advance taken while count equals match, with bit 3 set); bit 2, overflow (a wrap at the top of the count without interval mode). A bit is set only when the interrupt-enable bit in the same position is 1. A read of the status register returns the flags and clears them.
- R10: `irq_o` is 1 exactly when any status bit of any channel is set.
- R11: The count register is read-only. Writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| alt_tick_i | input | NCH | Per-channel external advance pulses |
| wave_o | output | NCH | Per-channel waveform outputs |
| irq_o | output | 1 | OR of all status flags |

## Verification
The waveform is decoded without registers straight from the count, so a wrong count shows on `wave_o` in the same cycle. Once the channel is stopped, it also shows as a wrong value in a count read. A prescaler phase that goes astray does not show on any output until the next advance is due. It then appears as a count that is off by a whole advance after 2^(p+1) clocks. A status flag that does not clear keeps `irq_o` high in the cycle after the clearing read. A flag that ignores its enable raises `irq_o` one cycle after the event.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

    localparam int unsigned DATA_W    = 32;
    localparam int unsigned ADDR_W    = 8;
    localparam int unsigned CH_STRIDE = 4;
    localparam int unsigned PS_W      = 4;
    localparam int unsigned EV_W      = 3;

    // register group base offsets (software decodes these)
    localparam logic [ADDR_W-1:0] OFS_CLK = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CTL = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_VAL = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_INT = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_MAT = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_STS = 8'h54;
    localparam logic [ADDR_W-1:0] OFS_IEN = 8'h60;

    localparam int unsigned CTL_CLR_BIT = 4;

    // clock-control word: bit5 source, bits4:1 exponent, bit0 prescale enable
    typedef struct packed {
        logic            src_alt;
        logic [PS_W-1:0] pscale;
        logic            pre_en;
    } clk_cfg_t;

    // counter-control fields
    typedef struct packed {
        logic pol;
        logic wave_off;
        logic match_en;
        logic intv_en;
        logic stop;
    } cnt_cfg_t;

    // event vector: bit2 overflow, bit1 match, bit0 interval wrap
    typedef struct packed {
        logic ovf;
        logic hit;
        logic wrap;
    } irq_ev_t;

    localparam cnt_cfg_t CTL_RST = '{pol: 1'b0, wave_off: 1'b1, match_en: 1'b0,
                                     intv_en: 1'b0, stop: 1'b1};

    function automatic logic [ADDR_W-1:0] slot_addr(logic [ADDR_W-1:0] base, int unsigned ch);
        return base + ADDR_W'(CH_STRIDE * ch);
    endfunction

    function automatic clk_cfg_t word_to_clk(logic [DATA_W-1:0] w);
        clk_cfg_t c;
        c.pre_en  = w[0];
        c.pscale  = w[PS_W:1];
        c.src_alt = w[PS_W+1];
        return c;
    endfunction

    function automatic cnt_cfg_t word_to_ctl(logic [DATA_W-1:0] w);
        cnt_cfg_t c;
        c.stop     = w[0];
        c.intv_en  = w[1];
        c.match_en = w[3];
        c.wave_off = w[5];
        c.pol      = w[6];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctl_to_word(cnt_cfg_t c);
        logic [DATA_W-1:0] w;
        w    = '0;
        w[0] = c.stop;
        w[1] = c.intv_en;
        w[3] = c.match_en;
        w[5] = c.wave_off;
        w[6] = c.pol;
        return w;
    endfunction

endpackage

// File: rtl/pwm3_prescale.sv
module pwm3_prescale
    import pwm3_pkg::*;
#(
    parameter int unsigned EXP_W = PS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             clr,
    input  logic             src_ev,
    input  logic             pre_en,
    input  logic [EXP_W-1:0] pscale,
    output logic             tick
);

    localparam int unsigned PRE_W = (2 ** EXP_W) + 1;

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] lim;
    logic             at_lim;

    assign lim    = (PRE_W'(1) << (int'(pscale) + 1)) - PRE_W'(1);
    assign at_lim = (pre_cnt == lim);
    assign tick   = src_ev && (!pre_en || at_lim);

    always_ff @(posedge clk) begin
        if (rst || clr || !run || !pre_en) begin
            pre_cnt <= '0;
        end else if (src_ev) begin
            pre_cnt <= at_lim ? '0 : pre_cnt + PRE_W'(1);
        end
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        (tick && pre_en && run && !clr) |=> (!tick || !pre_en)); // R4

endmodule

// File: rtl/pwm3_channel.sv
module pwm3_channel
    import pwm3_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  clk_cfg_t         clk_cfg,
    input  cnt_cfg_t         cnt_cfg,
    input  logic             clr_cnt,
    input  logic [CNT_W-1:0] intv_val,
    input  logic [CNT_W-1:0] match_val,
    input  logic [EV_W-1:0]  ien,
    input  logic             sts_rd,
    input  logic             alt_ev,
    output logic [CNT_W-1:0] count,
    output logic [EV_W-1:0]  sts,
    output logic             wave
);

    logic    run;
    logic    src_ev;
    logic    tick;
    logic    adv;
    logic    raw;
    irq_ev_t ev;

    assign run    = !cnt_cfg.stop;
    assign src_ev = clk_cfg.src_alt ? alt_ev : 1'b1;

    pwm3_prescale #(.EXP_W(PS_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .clr    (clr_cnt),
        .src_ev (src_ev),
        .pre_en (clk_cfg.pre_en),
        .pscale (clk_cfg.pscale),
        .tick   (tick)
    );

    assign adv     = tick && run;
    assign ev.wrap = adv && cnt_cfg.intv_en && (count >= intv_val);
    assign ev.ovf  = adv && !cnt_cfg.intv_en && (count == '1);
    assign ev.hit  = adv && cnt_cfg.match_en && (count == match_val);

    always_ff @(posedge clk) begin
        if (rst || clr_cnt) begin
            count <= '0;
        end else if (adv) begin
            count <= (ev.wrap || ev.ovf) ? '0 : count + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts <= '0;
        end else begin
            sts <= (sts & ~{EV_W{sts_rd}}) | (ev & ien);
        end
    end

    assign raw  = cnt_cfg.match_en && (count < match_val);
    assign wave = !cnt_cfg.wave_off && (raw ^ cnt_cfg.pol);

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (cnt_cfg.stop && !clr_cnt) |=> $stable(count)); // R3
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr_cnt |=> (count == '0)); // R8
    AST_INTV_WRAP: assert property (@(posedge clk) disable iff (rst)
        (tick && run && cnt_cfg.intv_en && (count >= intv_val) && !clr_cnt) |=> (count == '0)); // R6

    for (genvar b = 0; b < EV_W; b++) begin : g_mask
        AST_FLAG_MASKED: assert property (@(posedge clk) disable iff (rst)
            $rose(sts[b]) |-> $past(ien[b])); // R9
    end

endmodule

// File: rtl/pwm3_timer.sv
module pwm3_timer
    import pwm3_pkg::*;
#(
    parameter int unsigned NCH   = 3,
    parameter int unsigned CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NCH-1:0]    alt_tick_i,
    output logic [NCH-1:0]    wave_o,
    output logic              irq_o
);

    logic wr_stb;
    logic rd_stb;
    logic unused_wdata;

    assign wr_stb       = bus_sel && bus_wr;
    assign rd_stb       = bus_sel && !bus_wr;
    assign unused_wdata = ^bus_wdata;

    clk_cfg_t         clk_cfg_a [NCH];
    cnt_cfg_t         cnt_cfg_a [NCH];
    logic [CNT_W-1:0] intv_a    [NCH];
    logic [CNT_W-1:0] match_a   [NCH];
    logic [EV_W-1:0]  ien_a     [NCH];
    logic [CNT_W-1:0] count_a   [NCH];
    logic [EV_W-1:0]  sts_a     [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic             hit_clk, hit_ctl, hit_int, hit_mat, hit_sts, hit_ien;
        clk_cfg_t         clk_cfg_q;
        cnt_cfg_t         cnt_cfg_q;
        logic [CNT_W-1:0] intv_q;
        logic [CNT_W-1:0] match_q;
        logic [EV_W-1:0]  ien_q;
        logic             clr_cnt;
        logic             sts_rd;

        assign hit_clk = (bus_addr == slot_addr(OFS_CLK, g));
        assign hit_ctl = (bus_addr == slot_addr(OFS_CTL, g));
        assign hit_int = (bus_addr == slot_addr(OFS_INT, g));
        assign hit_mat = (bus_addr == slot_addr(OFS_MAT, g));
        assign hit_sts = (bus_addr == slot_addr(OFS_STS, g));
        assign hit_ien = (bus_addr == slot_addr(OFS_IEN, g));

        always_ff @(posedge clk) begin
            if (rst) begin
                clk_cfg_q <= '0;
                cnt_cfg_q <= CTL_RST;
                intv_q    <= '1;
                match_q   <= '0;
                ien_q     <= '0;
            end else if (wr_stb) begin
                if (hit_clk) clk_cfg_q <= word_to_clk(bus_wdata);
                if (hit_ctl) cnt_cfg_q <= word_to_ctl(bus_wdata);
                if (hit_int) intv_q    <= bus_wdata[CNT_W-1:0];
                if (hit_mat) match_q   <= bus_wdata[CNT_W-1:0];
                if (hit_ien) ien_q     <= bus_wdata[EV_W-1:0];
            end
        end

        assign clr_cnt = wr_stb && hit_ctl && bus_wdata[CTL_CLR_BIT];
        assign sts_rd  = rd_stb && hit_sts;

        pwm3_channel #(.CNT_W(CNT_W)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .clk_cfg   (clk_cfg_q),
            .cnt_cfg   (cnt_cfg_q),
            .clr_cnt   (clr_cnt),
            .intv_val  (intv_q),
            .match_val (match_q),
            .ien       (ien_q),
            .sts_rd    (sts_rd),
            .alt_ev    (alt_tick_i[g]),
            .count     (count_a[g]),
            .sts       (sts_a[g]),
            .wave      (wave_o[g])
        );

        assign clk_cfg_a[g] = clk_cfg_q;
        assign cnt_cfg_a[g] = cnt_cfg_q;
        assign intv_a[g]    = intv_q;
        assign match_a[g]   = match_q;
        assign ien_a[g]     = ien_q;
    end

    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            if (bus_addr == slot_addr(OFS_CLK, ch)) rd_mux = DATA_W'(clk_cfg_a[ch]);
            if (bus_addr == slot_addr(OFS_CTL, ch)) rd_mux = ctl_to_word(cnt_cfg_a[ch]);
            if (bus_addr == slot_addr(OFS_VAL, ch)) rd_mux = DATA_W'(count_a[ch]);
            if (bus_addr == slot_addr(OFS_INT, ch)) rd_mux = DATA_W'(intv_a[ch]);
            if (bus_addr == slot_addr(OFS_MAT, ch)) rd_mux = DATA_W'(match_a[ch]);
            if (bus_addr == slot_addr(OFS_STS, ch)) rd_mux = DATA_W'(sts_a[ch]);
            if (bus_addr == slot_addr(OFS_IEN, ch)) rd_mux = DATA_W'(ien_a[ch]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (rd_stb) begin
            bus_rdata <= rd_mux;
        end
    end

    always_comb begin
        irq_o = 1'b0;
        for (int ch = 0; ch < NCH; ch++) begin
            irq_o = irq_o | (|sts_a[ch]);
        end
    end

endmodule

// File: tb/pwm3_timer_tb.sv
module pwm3_timer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 3;
    localparam int CNT_W      = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  alt_tick_i = '0;
    logic [2:0]  wave_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_item_t;

    exp_item_t sb_q[$];
    logic      rd_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm3_timer #(.NCH(NCH), .CNT_W(CNT_W)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .alt_tick_i (alt_tick_i),
        .wave_o     (wave_o),
        .irq_o      (irq_o)
    );

    function automatic logic [7:0] ad(logic [7:0] base, int ch);
        return base + 8'(4 * ch);
    endfunction

    // monitor: pop expected read data once the design has produced it
    always @(posedge clk) rd_flag <= bus_sel && !bus_wr && !rst;

    always @(negedge clk) begin
        exp_item_t it;
        if (rd_flag && sb_q.size() > 0) begin
            it = sb_q.pop_front();
            checks++;
            if (bus_rdata !== it.exp) begin
                errors++;
                $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, bus_rdata, it.exp);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_item_t it;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic act, input logic e, input string tag);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, e);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(1);

        // R2 reset values
        rd(ad(8'h0C, 0), 32'h21, "R2 ctl reset");
        rd(ad(8'h00, 1), 32'h0,  "R2 clk reset");
        rd(ad(8'h24, 2), 32'hFF, "R2 interval reset");
        rd(ad(8'h30, 0), 32'h0,  "R2 match reset");
        rd(ad(8'h60, 1), 32'h0,  "R2 ien reset");
        rd(ad(8'h54, 0), 32'h0,  "R2 status reset");
        chk(|wave_o, 1'b0, "R2 wave reset");
        chk(irq_o, 1'b0, "R2 irq reset");

        // R1 map, stride and unmapped reads
        rd(8'h3C, 32'h0, "R1 unmapped 0x3C");
        rd(8'h70, 32'h0, "R1 unmapped 0x70");
        wr(ad(8'h30, 1), 32'h5A);
        wr(ad(8'h30, 2), 32'h33);
        rd(ad(8'h30, 1), 32'h5A, "R1 match ch1");
        rd(ad(8'h30, 2), 32'h33, "R1 match ch2");
        rd(ad(8'h30, 0), 32'h00, "R1 match ch0");

        // R8 reset bit not stored, others read back
        wr(ad(8'h0C, 2), 32'h7B);
        rd(ad(8'h0C, 2), 32'h6B, "R8 ctl readback");

        // R6 interval wrap: interval 9, 13 advances -> 3
        wr(ad(8'h24, 0), 32'd9);
        wr(ad(8'h30, 0), 32'd4);
        wr(ad(8'h0C, 0), 32'h0A);
        idle(12);
        wr(ad(8'h0C, 0), 32'h0B);
        rd(ad(8'h18, 0), 32'd3, "R6 interval wrap count");
        chk(wave_o[0], 1'b1, "R7 high below match");
        idle(5);
        rd(ad(8'h18, 0), 32'd3, "R3 stopped count holds");

        // R7 polarity, waveform off, match disabled
        wr(ad(8'h0C, 0), 32'h4B);
        chk(wave_o[0], 1'b0, "R7 inverted");
        wr(ad(8'h0C, 0), 32'h6B);
        chk(wave_o[0], 1'b0, "R7 waveform off");
        wr(ad(8'h30, 0), 32'd2);
        wr(ad(8'h0C, 0), 32'h0B);
        chk(wave_o[0], 1'b0, "R7 low at or above match");
        wr(ad(8'h0C, 0), 32'h43);
        chk(wave_o[0], 1'b1, "R7 match off inverted");

        // R8 counter clear
        wr(ad(8'h0C, 0), 32'h1B);
        rd(ad(8'h18, 0), 32'd0, "R8 count cleared");
        rd(ad(8'h0C, 0), 32'h0B, "R8 bit self-clears");
        chk(wave_o[0], 1'b1, "R8 wave after clear");

        // R4 prescale: exponent 1 -> every 4 clocks, 10 clocks -> 2
        wr(ad(8'h00, 1), 32'h03);
        wr(ad(8'h0C, 1), 32'h00);
        idle(9);
        wr(ad(8'h0C, 1), 32'h01);
        rd(ad(8'h18, 1), 32'd2, "R4 prescaled count");
        rd(ad(8'h00, 1), 32'h03, "R4 clk readback");
        wr(ad(8'h00, 1), 32'h02);
        wr(ad(8'h0C, 1), 32'h10);
        idle(4);
        wr(ad(8'h0C, 1), 32'h01);
        rd(ad(8'h18, 1), 32'd5, "R4 prescale disabled");

        // R5 external advance pulses
        wr(ad(8'h00, 2), 32'h20);
        wr(ad(8'h0C, 2), 32'h11);
        wr(ad(8'h0C, 2), 32'h00);
        idle(3);
        for (int i = 0; i < 3; i++) begin
            alt_tick_i[2] = 1'b1;
            @(negedge clk);
            alt_tick_i[2] = 1'b0;
            @(negedge clk);
        end
        wr(ad(8'h0C, 2), 32'h01);
        rd(ad(8'h18, 2), 32'd3, "R5 alt source count");

        // R9 / R10 interrupts on ch0: interval 9, match 2
        wr(ad(8'h60, 0), 32'h3);
        wr(ad(8'h0C, 0), 32'h0A);
        idle(14);
        wr(ad(8'h0C, 0), 32'h0B);
        chk(irq_o, 1'b1, "R10 irq raised");
        rd(ad(8'h54, 0), 32'h3, "R9 wrap and match flags");
        rd(ad(8'h54, 0), 32'h0, "R9 read clears");
        chk(irq_o, 1'b0, "R10 irq cleared");
        wr(ad(8'h60, 0), 32'h0);
        wr(ad(8'h0C, 0), 32'h0A);
        idle(12);
        wr(ad(8'h0C, 0), 32'h0B);
        rd(ad(8'h54, 0), 32'h0, "R9 masked flags");
        chk(irq_o, 1'b0, "R10 masked irq");

        // R6 / R9 overflow on ch1: count 5, 261 advances -> 10
        wr(ad(8'h60, 1), 32'h4);
        wr(ad(8'h0C, 1), 32'h00);
        idle(260);
        wr(ad(8'h0C, 1), 32'h01);
        rd(ad(8'h18, 1), 32'd10, "R6 free-run wrap count");
        chk(irq_o, 1'b1, "R10 overflow irq");
        rd(ad(8'h54, 1), 32'h4, "R9 overflow flag");
        chk(irq_o, 1'b0, "R10 overflow cleared");

        // R11 count is read-only
        wr(ad(8'h18, 1), 32'hAA);
        rd(ad(8'h18, 1), 32'd10, "R11 count write ignored");

        idle(3);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule